// File: doc/BRIEF.md
# Programmable Square-Wave Clock Generator

This block turns the system clock into a square wave of programmable frequency on a single output pin. A free-running up-counter, advanced once every two system clocks, climbs from a stored starting value to its all-ones state. At the all-ones state it reloads itself from that stored value. Each such wrap flips a toggle stage, so the pin spends the same number of clocks high as low. With a reload value `R` on a 16-bit counter, one full output cycle lasts `4 × (65536 − R)` system clocks. Reload `0xFFFF` gives a quarter of the system clock. Reload `0x0000` gives the slowest wave.

Software stores the starting value through a plain parallel write port. The same stored value may also pace a serial bit-rate generator elsewhere, so both rates follow from one number. Clock-out operation needs three things together: the timer/counter select set to timer, the output enable set, and the run bit set. When the block is not in clock-out mode, the counter still paces an overflow flag. This flag never sets while the pin is being driven.

Top module: `sqw_clkout`

## Requirements
- R1: After a synchronous active-low reset, `clk_out` is 0, `count` is 0, `ovf_flag` is 0 and the stored reload value is 0.
- R2: Clock-out mode is on only when `ct_sel` is 0 (timer) and `out_en` is 1. Whenever it is off, `clk_out` reads 0 in the same cycle and the toggle stage is cleared. After re-enabling, the first full level lasts a full half-period.
- R3: In clock-out mode, while running with reload value R, `clk_out` stays high for exactly 2×(2^W − R) clocks and low for exactly 2×(2^W − R) clocks (W = 16 by default). For example, R = 0xFFFF gives 2 and 2, and R = 0xFFF0 gives 32 and 32.
- R4: While `run` is 1 and `ct_sel` is 0, `count` changes exactly once every two clocks. Each change is either +1, or, from all-ones, a load of the stored reload value.
- R5: While `run` is 0, `count` and `clk_out` hold their values.
- R6: A reload write while `run` is 1 does not disturb the current count or the current half-period. The new value is first used at the next wrap. A write in the same cycle as a wrap stores the new value, but that wrap loads the previously stored value.
- R7: A reload write while `run` is 0 also presets `count` to the written value on the next clock.
- R8: A wrap with clock-out mode off and `ct_sel` = 0 sets `ovf_flag`. A wrap in clock-out mode never sets it. `flag_clr` = 1 clears it.
- R9: With `ct_sel` = 1 (counter mode), `count` does not advance and `clk_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 = counting enabled, 0 = hold |
| ct_sel | input | 1 | 0 = timer (system clock paced), 1 = counter mode (not advanced here) |
| out_en | input | 1 | 1 = drive the square wave onto `clk_out` |
| reload_wr | input | 1 | Write strobe for the reload value |
| reload_din | input | 16 | Reload value to store |
| clk_out | output | 1 | Square-wave output pin |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Overflow flag, set by wraps outside clock-out mode |
| flag_clr | input | 1 | Clears `ovf_flag` |

## Verification
The two functions that can meet in one cycle are a reload write and a counter wrap. The write stores the new value at the same edge where the wrap reads the stored value. To provoke this, the bench watches `count` until it first turns all-ones. It knows the next advance comes two clocks later, so it places the write strobe on exactly that edge. It then checks that `count` takes the old value at that wrap and the new value only at the wrap after. A second case writes in the middle of a half-period. There the bench judges, from the measured pin levels, that the running half keeps its old length and the next half takes the new one.

// File: rtl/sqw_pkg.sv
// Package: shared constants and types of the square-wave clock generator.
// Assumes nothing beyond IEEE 1800-2017.
package sqw_pkg;

    // Default counter width and system clocks per count step
    localparam int SQW_CNT_W   = 16;
    localparam int SQW_PRE_DIV = 2;

    // Timer/counter select encoding
    typedef enum logic {
        SEL_TIMER   = 1'b0,
        SEL_COUNTER = 1'b1
    } cnt_sel_e;

endpackage

// File: rtl/sqw_prescale.sv
// Module: sqw_prescale
// Divides the system clock so that one advance strobe appears every DIV
// clocks while the enable is high. The phase holds while the enable is low.
// Assumes DIV >= 2 and a synchronous active-low reset.
module sqw_prescale #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Phase counter: steps only while enabled, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (en) begin
            if (phase == LAST) begin
                phase <= '0;
            end else begin
                phase <= phase + PW'(1);
            end
        end
    end

    // Advance strobe on the last phase of each step
    always_comb begin
        tick = en && (phase == LAST);
    end

    // R4: two strobes are never adjacent
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sqw_reload_ctr.sv
// Module: sqw_reload_ctr
// Up-counter with a stored reload value. On an advance strobe at all-ones
// the counter loads the stored value and raises a one-cycle wrap pulse.
// A write stores a new reload value. When preset is allowed, the write also
// loads the counter directly. Assumes preset_ok and tick are never high
// together: the top only allows preset while stopped.
module sqw_reload_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         preset_ok,
    output logic [W-1:0] count,
    output logic         wrap
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] reload_q;
    logic         at_top;

    // Reload storage: written whenever the strobe is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr) begin
            reload_q <= wdata;
        end
    end

    // Detect the all-ones state of the counter
    always_comb begin
        at_top = (count == ALL_ONES);
    end

    // Wrap pulse: an advance strobe arriving at all-ones
    always_comb begin
        wrap = tick && at_top;
    end

    // Counter: preset while stopped, otherwise advance or reload on strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr && preset_ok) begin
            count <= wdata;
        end else if (tick) begin
            if (at_top) begin
                count <= reload_q;
            end else begin
                count <= count + W'(1);
            end
        end
    end

    // R4 / R6: a wrap loads the value stored before that edge
    a_r4_wrap_load: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == $past(reload_q)));

    // R5: without a strobe or a preset, the count holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(wr && preset_ok)) |=> $stable(count));

    // R6: a strobe that is not a wrap moves the count by one
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_top) |=> (count == $past(count) + W'(1)));

    // Interface assumption: preset and advance never coincide
    a_r7_preset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        preset_ok |-> !tick);

endmodule

// File: rtl/sqw_toggle.sv
// Module: sqw_toggle
// Toggle stage for the output pin. It flips on each wrap while clock-out
// mode is on, and it is held cleared while the mode is off. The pin level
// is gated with the mode, so it drops in the same cycle the mode turns off.
// Assumes a synchronous active-low reset.
module sqw_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_on,
    input  logic wrap,
    output logic pin
);

    logic level_q;

    // Toggle flip-flop: flips on a wrap, cleared outside clock-out mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else if (!mode_on) begin
            level_q <= 1'b0;
        end else if (wrap) begin
            level_q <= !level_q;
        end
    end

    // Pin drive: low whenever the mode is off
    always_comb begin
        pin = level_q && mode_on;
    end

    // R2: the stage is cleared one edge after the mode is off
    a_r2_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |=> !level_q);

    // R3: every wrap in clock-out mode flips the stage
    a_r3_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_on && wrap) |=> (level_q != $past(level_q)));

    // R5: with no wrap in clock-out mode the stage holds
    a_r5_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_on && !wrap) |=> $stable(level_q));

endmodule

// File: rtl/sqw_clkout.sv
// Module: sqw_clkout (top)
// Programmable square-wave clock generator. A prescaled auto-reload counter
// drives a toggle stage on the output pin. The pin frequency is
// f_clk / (2*DIV*(2^W - reload)), which is f_clk / (4*(65536 - reload))
// with the default parameters. Wraps set the overflow flag only when
// clock-out mode is off. Counter mode (ct_sel = 1) leaves the count parked.
// Assumes all inputs are synchronous to clk.
module sqw_clkout
    import sqw_pkg::*;
#(
    parameter int CNT_W   = SQW_CNT_W,
    parameter int PRE_DIV = SQW_PRE_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ct_sel,
    input  logic             out_en,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_din,
    output logic             clk_out,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    input  logic             flag_clr
);

    cnt_sel_e sel;
    logic     timer_sel;
    logic     mode_on;
    logic     adv_en;
    logic     tick;
    logic     wrap;

    // Mode decode from the control bits
    always_comb begin
        sel       = cnt_sel_e'(ct_sel);
        timer_sel = (sel == SEL_TIMER);
        mode_on   = timer_sel && out_en;
        adv_en    = timer_sel && run;
    end

    sqw_prescale #(
        .DIV (PRE_DIV)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv_en),
        .tick  (tick)
    );

    sqw_reload_ctr #(
        .W (CNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr        (reload_wr),
        .wdata     (reload_din),
        .preset_ok (!run),
        .count     (count),
        .wrap      (wrap)
    );

    sqw_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_on (mode_on),
        .wrap    (wrap),
        .pin     (clk_out)
    );

    // Overflow flag: set by wraps outside clock-out mode, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (wrap && !mode_on) begin
            ovf_flag <= 1'b1;
        end else if (flag_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    // R8: clock-out mode never raises the flag
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        mode_on |=> !$rose(ovf_flag));

    // R9: counter mode parks the count unless a preset lands
    a_r9_park: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_sel && !reload_wr) |=> $stable(count));

    // R9: pin is low in counter mode
    a_r9_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        ct_sel |-> !clk_out);

endmodule

// File: tb/sim_sqw_clkout.sv
// Directed bench for sqw_clkout: one task per scenario, each checking itself.
module sim_sqw_clkout;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic        ct_sel;
    logic        out_en;
    logic        reload_wr;
    logic [15:0] reload_din;
    logic        clk_out;
    logic [15:0] count;
    logic        ovf_flag;
    logic        flag_clr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    sqw_clkout u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .ct_sel     (ct_sel),
        .out_en     (out_en),
        .reload_wr  (reload_wr),
        .reload_din (reload_din),
        .clk_out    (clk_out),
        .count      (count),
        .ovf_flag   (ovf_flag),
        .flag_clr   (flag_clr)
    );

    always #(CLK_PERIOD / 2) clk = !clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Store a reload value with a one-cycle strobe
    task automatic write_reload(input logic [15:0] v);
        reload_din = v;
        reload_wr  = 1'b1;
        @(negedge clk);
        reload_wr  = 1'b0;
    endtask

    // Measure one high level and the following low level of the pin
    task automatic measure(output int hi, output int lo);
        int guard = 0;
        hi = 0;
        lo = 0;
        while (clk_out !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
        while (clk_out !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
        while (clk_out === 1'b1 && guard < 20000) begin hi++; @(negedge clk); guard++; end
        while (clk_out === 1'b0 && guard < 20000) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run = 1'b0; ct_sel = 1'b0; out_en = 1'b0;
        reload_wr = 1'b0; reload_din = '0; flag_clr = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "clk_out after reset", int'(clk_out), 0);
        check("R1", "count after reset", int'(count), 0);
        check("R1", "ovf_flag after reset", int'(ovf_flag), 0);
    endtask

    task automatic t_fast_and_slow();
        int hi, lo;
        out_en = 1'b1;
        write_reload(16'hFFFF);
        check("R7", "preset while stopped", int'(count), 16'hFFFF);
        run = 1'b1;
        for (int k = 0; k < 3; k++) begin
            measure(hi, lo);
            check("R3", "high length, reload FFFF", hi, 2);
            check("R3", "low length, reload FFFF", lo, 2);
        end
        run = 1'b0;
        @(negedge clk);
        write_reload(16'hFFF0);
        check("R7", "preset FFF0", int'(count), 16'hFFF0);
        run = 1'b1;
        for (int k = 0; k < 2; k++) begin
            measure(hi, lo);
            check("R3", "high length, reload FFF0", hi, 32);
            check("R3", "low length, reload FFF0", lo, 32);
        end
        check("R8", "no flag in clock-out mode", int'(ovf_flag), 0);
    endtask

    task automatic t_write_mid_period();
        int hi = 0, lo = 0, guard = 0;
        while (clk_out !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
        while (clk_out !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
        while (clk_out === 1'b1 && guard < 2000) begin
            hi++;
            if (hi == 5) begin
                reload_din = 16'hFFFC;
                reload_wr  = 1'b1;
            end else begin
                reload_wr  = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        reload_wr = 1'b0;
        while (clk_out === 1'b0 && guard < 2000) begin lo++; @(negedge clk); guard++; end
        check("R6", "running half keeps old length", hi, 32);
        check("R6", "next half uses new reload", lo, 8);
    endtask

    task automatic wait_top();
        logic [15:0] prev = count;
        int guard = 0;
        @(negedge clk);
        while (!(count == 16'hFFFF && prev != 16'hFFFF) && guard < 2000) begin
            prev = count;
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_write_at_wrap();
        wait_top();
        @(negedge clk);
        reload_din = 16'hFFF8;
        reload_wr  = 1'b1;
        @(negedge clk);
        reload_wr  = 1'b0;
        check("R6", "wrap with coincident write loads old value", int'(count), 16'hFFFC);
        wait_top();
        cyc(2);
        check("R6", "following wrap loads new value", int'(count), 16'hFFF8);
    endtask

    task automatic t_stop_hold();
        logic [15:0] c;
        logic        p;
        run = 1'b0;
        @(negedge clk);
        c = count;
        p = clk_out;
        cyc(20);
        check("R5", "count held while stopped", int'(count), int'(c));
        check("R5", "pin held while stopped", int'(clk_out), int'(p));
        run = 1'b1;
    endtask

    task automatic t_disable_and_flag();
        int changes = 0, bad = 0, pin_hi = 0;
        logic [15:0] prev;
        out_en = 1'b0;
        @(negedge clk);
        prev = count;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (clk_out) pin_hi++;
            if (count != prev) begin
                changes++;
                if (!(count == prev + 16'd1 || (prev == 16'hFFFF && count == 16'hFFF8))) bad++;
            end
            prev = count;
        end
        check("R2", "pin low with output disabled", pin_hi, 0);
        check("R4", "count changes in 40 clocks", changes, 20);
        check("R4", "illegal count steps", bad, 0);
        check("R8", "flag set by wrap outside clock-out mode", int'(ovf_flag), 1);
        run = 1'b0;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R8", "flag cleared", int'(ovf_flag), 0);
        run = 1'b1;
    endtask

    task automatic t_counter_mode();
        logic [15:0] c;
        int pin_hi = 0;
        ct_sel = 1'b1;
        out_en = 1'b1;
        @(negedge clk);
        c = count;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_out) pin_hi++;
        end
        check("R9", "count parked in counter mode", int'(count), int'(c));
        check("R9", "pin low in counter mode", pin_hi, 0);
        ct_sel = 1'b0;
    endtask

    task automatic t_reenable();
        int hi, lo;
        measure(hi, lo);
        check("R2", "high length after re-enable", hi, 16);
        check("R2", "low length after re-enable", lo, 16);
        cyc(40);
        check("R8", "no flag after re-enable", int'(ovf_flag), 0);
    endtask

    initial begin
        t_reset();
        t_fast_and_slow();
        t_write_mid_period();
        t_write_at_wrap();
        t_stop_hold();
        t_disable_and_flag();
        t_counter_mode();
        t_reenable();
        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < WDOG_CYC) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", n);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule